// File: doc/BRIEF.md
# 64-bit SECDED Check and Single-Bit Locator

This block takes a 64-bit word, supplied as an upper and a lower 32-bit half, together with the 8 check bits that were stored alongside it. It recomputes the check bits from a fixed parity matrix and XORs them with the received ones to form a syndrome. It then classifies the word: clean, one flipped data bit, one flipped check bit, or an uncorrectable pattern.

The locator does not decode the syndrome by position. It compares the syndrome against the matrix column that belongs to each data bit and takes the lowest matching index. Only when no data column matches does it consider a single check bit. The block returns the repaired data and check byte. Every result is registered and is qualified by a valid flag that follows the input strobe by one clock.

Top module: `secded64_check`

## Requirements
- R1: Check bit i is the XOR parity of the word {in_hi,in_lo} ANDed with a 64-bit mask written upper:lower. The masks are: i=0 f00fe11e:c33c0ff7, i=1 00ff00ff:00fff0ff, i=2 0f0f0f0f:0f0fff00, i=3 11113333:7777000f, i=4 22224444:8888222f, i=5 44448888:ffff4441, i=6 8888ffff:11118882, i=7 ffff1111:22221114. The `syndrome` output is this computed byte XOR in_chk, with bit i of the byte at position i.
- R2: Data bit index k (0..63) addresses in_lo[k] when k<32 and in_hi[k-32] otherwise. The expected syndrome of data bit k has bit i equal to bit k of mask i.
- R3: A zero syndrome raises none of sbe, mbe, data_hit or chk_hit. The indices read 0, and fix_hi, fix_lo and fix_chk equal the inputs.
- R4: A nonzero syndrome equal to the column of some data bit raises data_hit and sbe. bad_data_idx names the lowest such index, and bad_chk_idx reads 0.
- R5: When data_hit is raised, {fix_hi,fix_lo} equals the input word with bit bad_data_idx inverted, and fix_chk equals in_chk.
- R6: A nonzero syndrome with exactly one bit set that matches no data column raises chk_hit and sbe. bad_chk_idx names that bit, fix_chk is in_chk with that bit inverted, and the data passes unchanged.
- R7: A nonzero syndrome that matches no data column and has two or more bits set raises mbe only. Both indices read 0, and all fix outputs equal the inputs.
- R8: out_valid is high exactly one cycle after a cycle with in_valid high. When in_valid is low, every result output holds its previous value.
- R9: After a synchronous reset, out_valid and all result outputs are 0. At most one of data_hit, chk_hit and mbe is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_hi | input | 32 | Data bits 63..32 |
| in_lo | input | 32 | Data bits 31..0 |
| in_chk | input | 8 | Received check bits |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| sbe | output | 1 | Correctable single-bit error |
| mbe | output | 1 | Uncorrectable error |
| data_hit | output | 1 | Single error located in data |
| chk_hit | output | 1 | Single error located in check bits |
| bad_data_idx | output | 6 | Index of faulty data bit |
| bad_chk_idx | output | 3 | Index of faulty check bit |
| syndrome | output | 8 | Computed check bits XOR received |
| fix_hi | output | 32 | Corrected data bits 63..32 |
| fix_lo | output | 32 | Corrected data bits 31..0 |
| fix_chk | output | 8 | Corrected check bits |

## Verification
On every cycle, the assertions check the valid delay and the holding of results while idle. They also check that the three outcome flags exclude one another, that each repair inverts exactly one bit against the word captured a cycle earlier, that a clean syndrome passes the data through unchanged, and that an uncorrectable result carries a multi-bit syndrome. Only the bench scenarios can confirm the mask constants themselves, the exact index chosen when a column matches, the lowest-index priority, and the boundary indices 0, 31, 32 and 63. The bench does this by comparing against an independently computed parity and column search.

// File: rtl/secded64_pkg.sv
package secded64_pkg;
  localparam int HALF_W = 32;
  localparam int WORD_W = 2 * HALF_W;
  localparam int CHK_W  = 8;
  localparam int DIDX_W = $clog2(WORD_W);
  localparam int CIDX_W = $clog2(CHK_W);

  // Parity selection mask of check bit i, upper half first.
  function automatic logic [WORD_W-1:0] parity_mask(input int i);
    case (i)
      0: return {32'hf00fe11e, 32'hc33c0ff7};
      1: return {32'h00ff00ff, 32'h00fff0ff};
      2: return {32'h0f0f0f0f, 32'h0f0fff00};
      3: return {32'h11113333, 32'h7777000f};
      4: return {32'h22224444, 32'h8888222f};
      5: return {32'h44448888, 32'hffff4441};
      6: return {32'h8888ffff, 32'h11118882};
      default: return {32'hffff1111, 32'h22221114};
    endcase
  endfunction
endpackage

// File: rtl/secded64_parity.sv
module secded64_parity
  import secded64_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int C = CHK_W
) (
  input  logic [W-1:0] word,
  output logic [C-1:0] chk
);
  // One reduction tree per check bit.
  for (genvar gi = 0; gi < C; gi++) begin : g_par
    localparam logic [W-1:0] MASK = parity_mask(gi);
    assign chk[gi] = ^(word & MASK);
  end
endmodule

// File: rtl/secded64_first_set.sv
module secded64_first_set #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins: scan from the top so the last write is the lowest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int j = W - 1; j >= 0; j--) begin
      if (vec[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/secded64_locate.sv
module secded64_locate
  import secded64_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int C  = CHK_W,
  parameter int DW = $clog2(W),
  parameter int CW = $clog2(C)
) (
  input  logic [C-1:0]  syn,
  output logic          data_hit,
  output logic [DW-1:0] data_idx,
  output logic          chk_hit,
  output logic [CW-1:0] chk_idx,
  output logic          multi
);
  logic [W-1:0]  match;
  logic          d_found;
  logic [DW-1:0] d_idx;
  logic          c_found;
  logic [CW-1:0] c_idx;
  logic          nonzero;
  logic          single;

  assign nonzero = |syn;
  assign single  = nonzero && ((syn & (syn - C'(1))) == '0);

  // Column of data bit k: bit k of every parity mask.
  for (genvar gk = 0; gk < W; gk++) begin : g_col
    logic [C-1:0] col;
    always_comb begin
      for (int i = 0; i < C; i++) begin
        col[i] = parity_mask(i)[gk];
      end
    end
    assign match[gk] = nonzero && (syn == col);
  end

  secded64_first_set #(.W(W), .IW(DW)) u_data_pick (
    .vec(match), .found(d_found), .idx(d_idx)
  );

  secded64_first_set #(.W(C), .IW(CW)) u_chk_pick (
    .vec(syn), .found(c_found), .idx(c_idx)
  );

  assign data_hit = d_found;
  assign data_idx = d_found ? d_idx : '0;
  assign chk_hit  = !d_found && single && c_found;
  assign chk_idx  = chk_hit ? c_idx : '0;
  assign multi    = nonzero && !d_found && !single;
endmodule

// File: rtl/secded64_check.sv
module secded64_check
  import secded64_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int CB = CHK_W,
  localparam int WW = 2 * HW,
  localparam int DW = $clog2(WW),
  localparam int CW = $clog2(CB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [HW-1:0] in_hi,
  input  logic [HW-1:0] in_lo,
  input  logic [CB-1:0] in_chk,
  output logic          out_valid,
  output logic          sbe,
  output logic          mbe,
  output logic          data_hit,
  output logic          chk_hit,
  output logic [DW-1:0] bad_data_idx,
  output logic [CW-1:0] bad_chk_idx,
  output logic [CB-1:0] syndrome,
  output logic [HW-1:0] fix_hi,
  output logic [HW-1:0] fix_lo,
  output logic [CB-1:0] fix_chk
);
  logic [WW-1:0] word;
  logic [CB-1:0] calc_chk;
  logic [CB-1:0] syn_c;
  logic          dh_c, ch_c, mb_c;
  logic [DW-1:0] di_c;
  logic [CW-1:0] ci_c;
  logic [WW-1:0] fix_word_c;
  logic [CB-1:0] fix_chk_c;

  assign word = {in_hi, in_lo};

  secded64_parity #(.W(WW), .C(CB)) u_par (
    .word(word), .chk(calc_chk)
  );

  assign syn_c = calc_chk ^ in_chk;

  secded64_locate #(.W(WW), .C(CB), .DW(DW), .CW(CW)) u_loc (
    .syn(syn_c), .data_hit(dh_c), .data_idx(di_c),
    .chk_hit(ch_c), .chk_idx(ci_c), .multi(mb_c)
  );

  // Repair: invert the one located bit, otherwise pass through.
  always_comb begin
    fix_word_c = word;
    fix_chk_c  = in_chk;
    if (dh_c) fix_word_c[di_c] = ~word[di_c];
    if (ch_c) fix_chk_c[ci_c]  = ~in_chk[ci_c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      sbe          <= 1'b0;
      mbe          <= 1'b0;
      data_hit     <= 1'b0;
      chk_hit      <= 1'b0;
      bad_data_idx <= '0;
      bad_chk_idx  <= '0;
      syndrome     <= '0;
      fix_hi       <= '0;
      fix_lo       <= '0;
      fix_chk      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sbe          <= dh_c | ch_c;
        mbe          <= mb_c;
        data_hit     <= dh_c;
        chk_hit      <= ch_c;
        bad_data_idx <= di_c;
        bad_chk_idx  <= ci_c;
        syndrome     <= syn_c;
        fix_hi       <= fix_word_c[WW-1:HW];
        fix_lo       <= fix_word_c[HW-1:0];
        fix_chk      <= fix_chk_c;
      end
    end
  end

  // R8: valid follows the strobe by one cycle
  a_r8_valid_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: results hold while no word is presented
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(syndrome) && $stable(fix_hi) && $stable(fix_lo)
                   && $stable(fix_chk) && $stable(mbe) && $stable(sbe)));
  // R9: outcome flags exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_hit, chk_hit, mbe}));
  // R3: clean word passes through
  a_r3_clean_pass: assert property (@(posedge clk) disable iff (rst)
    in_valid ##1 (syndrome == '0) |->
      ({fix_hi, fix_lo} == $past(word)) && (fix_chk == $past(in_chk)) && !sbe && !mbe);
  // R5: data repair flips exactly one bit
  a_r5_one_flip: assert property (@(posedge clk) disable iff (rst)
    in_valid ##1 data_hit |->
      ($countones({fix_hi, fix_lo} ^ $past(word)) == 1) && (fix_chk == $past(in_chk)));
  // R6: check repair flips exactly one check bit
  a_r6_one_flip: assert property (@(posedge clk) disable iff (rst)
    in_valid ##1 chk_hit |->
      ($countones(fix_chk ^ $past(in_chk)) == 1) && ({fix_hi, fix_lo} == $past(word)));
  // R7: uncorrectable implies multi-bit syndrome
  a_r7_multi: assert property (@(posedge clk) disable iff (rst)
    out_valid && mbe |-> ($countones(syndrome) > 1));
endmodule

// File: tb/sim_secded64_check.sv
`timescale 1ns/1ps
module sim_secded64_check;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_hi, in_lo;
  logic [7:0]  in_chk;
  logic        out_valid, sbe, mbe, data_hit, chk_hit;
  logic [5:0]  bad_data_idx;
  logic [2:0]  bad_chk_idx;
  logic [7:0]  syndrome;
  logic [31:0] fix_hi, fix_lo;
  logic [7:0]  fix_chk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  secded64_check u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi(in_hi), .in_lo(in_lo),
    .in_chk(in_chk), .out_valid(out_valid), .sbe(sbe), .mbe(mbe),
    .data_hit(data_hit), .chk_hit(chk_hit), .bad_data_idx(bad_data_idx),
    .bad_chk_idx(bad_chk_idx), .syndrome(syndrome), .fix_hi(fix_hi),
    .fix_lo(fix_lo), .fix_chk(fix_chk)
  );

  // Masks as listed in R1.
  function automatic logic [63:0] ref_mask(input int i);
    logic [63:0] m [8];
    m[0] = 64'hf00fe11e_c33c0ff7; m[1] = 64'h00ff00ff_00fff0ff;
    m[2] = 64'h0f0f0f0f_0f0fff00; m[3] = 64'h11113333_7777000f;
    m[4] = 64'h22224444_8888222f; m[5] = 64'h44448888_ffff4441;
    m[6] = 64'h8888ffff_11118882; m[7] = 64'hffff1111_22221114;
    return m[i];
  endfunction

  function automatic logic [7:0] ref_enc(input logic [63:0] w);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      c[i] = 1'b0;
      for (int k = 0; k < 64; k++) if (ref_mask(i)[k]) c[i] ^= w[k];
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_col(input int k);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) c[i] = ref_mask(i)[k];
    return c;
  endfunction

  task automatic chk1(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Present one word and check every output against the requirement model.
  task automatic run_word(input logic [31:0] hi, input logic [31:0] lo,
                          input logic [7:0] c);
    logic [63:0] w;
    logic [7:0]  s;
    int          dk;
    int          ones;
    int          cj;
    logic [63:0] ew;
    logic [7:0]  ec;
    w = {hi, lo};
    s = ref_enc(w) ^ c;
    dk = -1;
    if (s != 0) begin
      for (int k = 63; k >= 0; k--) if (ref_col(k) == s) dk = k;
    end
    ones = $countones(s);
    cj = -1;
    if (dk < 0 && ones == 1) begin
      for (int j = 7; j >= 0; j--) if (s[j]) cj = j;
    end
    ew = w; ec = c;
    if (dk >= 0) ew[dk] = ~ew[dk];
    if (cj >= 0) ec[cj] = ~ec[cj];
    @(negedge clk);
    in_hi = hi; in_lo = lo; in_chk = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk1("R8", "out_valid", 64'(out_valid), 64'd1);
    chk1("R1", "syndrome", 64'(syndrome), 64'(s));
    if (s == 0) begin
      chk1("R3", "flags", 64'({sbe, mbe, data_hit, chk_hit}), 64'd0);
      chk1("R3", "fix", {fix_hi, fix_lo}, w);
    end else if (dk >= 0) begin
      chk1("R4", "flags", 64'({sbe, mbe, data_hit, chk_hit}), 64'b1010);
      chk1("R4", "bad_data_idx", 64'(bad_data_idx), 64'(dk));
      chk1("R5", "fix data", {fix_hi, fix_lo}, ew);
      chk1("R5", "fix_chk", 64'(fix_chk), 64'(c));
    end else if (cj >= 0) begin
      chk1("R6", "flags", 64'({sbe, mbe, data_hit, chk_hit}), 64'b1001);
      chk1("R6", "bad_chk_idx", 64'(bad_chk_idx), 64'(cj));
      chk1("R6", "fix_chk", 64'(fix_chk), 64'(ec));
      chk1("R6", "fix data", {fix_hi, fix_lo}, w);
    end else begin
      chk1("R7", "flags", 64'({sbe, mbe, data_hit, chk_hit}), 64'b0100);
      chk1("R7", "indices", 64'({bad_data_idx, bad_chk_idx}), 64'd0);
      chk1("R7", "fix", {fix_hi, fix_lo, fix_chk}, {w, c});
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b0; in_hi = '1; in_lo = '1; in_chk = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk1("R9", "reset state", {out_valid, sbe, mbe, data_hit, chk_hit, bad_data_idx,
         bad_chk_idx, syndrome, fix_chk}, 64'd0);
    chk1("R9", "reset fix", {fix_hi, fix_lo}, 64'd0);
  endtask

  task automatic test_clean();  // R3
    logic [63:0] w;
    w = 64'h0; run_word(w[63:32], w[31:0], ref_enc(w));
    w = '1;    run_word(w[63:32], w[31:0], ref_enc(w));
    w = 64'h0123_4567_89ab_cdef; run_word(w[63:32], w[31:0], ref_enc(w));
  endtask

  task automatic test_data_flips();  // R2 R4 R5 boundaries
    logic [63:0] w;
    int ks [8] = '{0, 1, 17, 31, 32, 47, 62, 63};
    w = 64'hdead_beef_cafe_f00d;
    foreach (ks[n]) begin
      logic [63:0] b;
      b = w; b[ks[n]] = ~b[ks[n]];
      run_word(b[63:32], b[31:0], ref_enc(w));
    end
  endtask

  task automatic test_chk_flips();  // R6
    logic [63:0] w;
    w = 64'h5555_aaaa_3333_cccc;
    for (int j = 0; j < 8; j++) begin
      logic [7:0] c;
      c = ref_enc(w); c[j] = ~c[j];
      run_word(w[63:32], w[31:0], c);
    end
  endtask

  task automatic test_multi();  // R7
    logic [63:0] w, b;
    w = 64'h1357_9bdf_2468_ace0;
    b = w ^ 64'h3;                     run_word(b[63:32], b[31:0], ref_enc(w));
    b = w ^ (64'h1 << 40) ^ 64'h20;    run_word(b[63:32], b[31:0], ref_enc(w));
    b = w ^ 64'h1;                     run_word(b[63:32], b[31:0], ref_enc(w) ^ 8'h01);
    run_word(w[63:32], w[31:0], ~ref_enc(w));
  endtask

  task automatic test_hold();  // R8
    logic [63:0] keep;
    logic [7:0]  ks;
    keep = {fix_hi, fix_lo}; ks = syndrome;
    @(negedge clk);
    in_hi = 32'h0; in_lo = 32'hffff; in_chk = 8'h5a;
    @(negedge clk);
    chk1("R8", "idle out_valid", 64'(out_valid), 64'd0);
    chk1("R8", "idle hold fix", {fix_hi, fix_lo}, keep);
    chk1("R8", "idle hold syndrome", 64'(syndrome), 64'(ks));
  endtask

  initial begin
    #2000000ns;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_clean();
    test_data_flips();
    test_chk_flips();
    test_multi();
    test_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule